// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a 2048 x 8 byte memory reached over a two-wire serial bus. It oversamples the clock and data lines with the system clock and finds start and stop conditions. It then decodes a device byte whose middle bits choose one of eight 256-byte pages, and it acknowledges or declines each byte by pulling the data line low through an active-high enable. The array sits inside the block as a synchronous RAM. Writes finish within the acknowledge slot, so the block never reports busy.

A write transfer carries the device byte, then a low-address byte, then any number of data bytes. A read transfer carries only the device byte. It takes the page from that byte and the low address bits from the internal latch, so it carries on from wherever the previous access left off. To read from a chosen address, the host sends a write transfer that ends after the low-address byte, then starts a read. A write-protect input blocks every array write while it is high.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, and whenever the block is idle, the data pull-low enable `sda_pull` is 0.
- R2: A falling data line while the clock is high (start) always begins a new device byte, even in the middle of a transfer. A rising data line while the clock is high (stop) returns the block to idle. Bytes clocked after a stop and before the next start get no acknowledge.
- R3: The device byte is sent MSB first: bits 7:4 must equal 4'b1010, bits 3:1 are address bits 10:8, and bit 0 selects direction (0 = write, 1 = read). A matching byte is acknowledged. Any other byte is not acknowledged, and every later byte is ignored until the next start.
- R4: In a write, the byte after the device byte is acknowledged and sets address bits 7:0. Each following data byte, sent MSB first, is stored at the current address and acknowledged.
- R5: The 11-bit address latch advances by one after every data byte that is read or stored, and it wraps from 7FFh to 000h.
- R6: A read has no address byte. It starts at {page bits, latched bits 7:0} and drives 8 bits MSB first, with the first bit placed on the clock fall that ends the device acknowledge. An acknowledge from the host yields the next byte. A non-acknowledge releases the data line.
- R7: While `wp_in` is 1, data bytes are not acknowledged, the array keeps its contents, and the address latch does not advance. The device and address bytes are still acknowledged.
- R8: A start or stop that arrives before the eighth bit of a data byte leaves the array and the address latch unchanged.
- R9: `sda_pull` changes only while the bus clock is low.
- R10: A device byte sent at once after a completed write is acknowledged, because there is no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| wp_in | input | 1 | Write protect, 1 blocks all array writes |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |

## Verification
Some properties are checked on every cycle. `sda_pull` may change only on the cycle after a detected clock fall. The block must be released whenever it is idle. No array write may happen while protect is high. Each array write must advance the latch by exactly one modulo 2048. A detected start must lead straight to device-byte reception. The bench scenarios cover the rest: stored and returned byte values, page and latch composition for reads, the wrap from the top address to zero, declined device bytes, aborted bytes that leave old contents in place, and the latch holding still under protect. These can only be seen by writing through the bus and reading back.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVID,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } twi_state_e;
endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // stage STAGES-1 is the synchronized value, stage STAGES the one before it
    logic [STAGES:0] scl_sh_q;
    logic [STAGES:0] sda_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
        end else begin
            scl_sh_q <= {scl_sh_q[STAGES-1:0], scl_in};
            sda_sh_q <= {sda_sh_q[STAGES-1:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_old;
    assign scl_now   = scl_sh_q[STAGES-1];
    assign scl_old   = scl_sh_q[STAGES];
    assign sda_s     = sda_sh_q[STAGES-1];
    assign sda_old   = sda_sh_q[STAGES];
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_s;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int          ADDR_W = 11,
    parameter int          DATA_W = 8,
    parameter logic [3:0]  DEV_ID = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wp_in,
    output logic sda_pull
);
    localparam int PAGE_W = ADDR_W - DATA_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        twi_state_e        state;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] tx;
        logic [ADDR_W-1:0] addr;
        logic              rw;
        logic              acked;
        logic              pull;
    } ctl_t;

    ctl_t st_d, st_q;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic mem_we;
    logic [DATA_W-1:0] mem_rd;

    twi_bus_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.addr),
        .wdata (st_q.shreg),
        .raddr (st_q.addr),
        .rdata (mem_rd)
    );

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;

        // receive phases shift one bit per clock rise, MSB first
        if (scl_rise && st_q.bitcnt != CNT_FULL &&
            (st_q.state == ST_DEVID || st_q.state == ST_WADDR || st_q.state == ST_WDATA)) begin
            st_d.shreg  = {st_q.shreg[DATA_W-2:0], sda_s};
            st_d.bitcnt = st_q.bitcnt + 1'b1;
        end

        case (st_q.state)
            ST_DEVID: if (scl_fall && st_q.bitcnt == CNT_FULL) begin
                if (st_q.shreg[DATA_W-1:PAGE_W+1] == DEV_ID) begin
                    st_d.addr[ADDR_W-1:DATA_W] = st_q.shreg[PAGE_W:1];
                    st_d.rw    = st_q.shreg[0];
                    st_d.pull  = 1'b1;
                    st_d.state = ST_DEV_ACK;
                end else begin
                    st_d.state = ST_IDLE;
                end
            end
            ST_DEV_ACK: if (scl_fall) begin
                st_d.bitcnt = '0;
                if (st_q.rw) begin
                    st_d.tx    = mem_rd;
                    st_d.pull  = ~mem_rd[DATA_W-1];
                    st_d.state = ST_RDATA;
                end else begin
                    st_d.pull  = 1'b0;
                    st_d.state = ST_WADDR;
                end
            end
            ST_WADDR: if (scl_fall && st_q.bitcnt == CNT_FULL) begin
                st_d.addr[DATA_W-1:0] = st_q.shreg;
                st_d.pull  = 1'b1;
                st_d.state = ST_WADDR_ACK;
            end
            ST_WADDR_ACK, ST_WDATA_ACK: if (scl_fall) begin
                st_d.pull   = 1'b0;
                st_d.bitcnt = '0;
                st_d.state  = ST_WDATA;
            end
            ST_WDATA: if (scl_fall && st_q.bitcnt == CNT_FULL) begin
                if (!wp_in) begin
                    mem_we     = 1'b1;
                    st_d.addr  = st_q.addr + 1'b1;
                    st_d.pull  = 1'b1;
                end
                st_d.state = ST_WDATA_ACK;
            end
            ST_RDATA: if (scl_fall) begin
                if (st_q.bitcnt == CNT_LAST) begin
                    st_d.pull  = 1'b0;
                    st_d.addr  = st_q.addr + 1'b1;
                    st_d.state = ST_RACK;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                    st_d.tx     = {st_q.tx[DATA_W-2:0], 1'b0};
                    st_d.pull   = ~st_q.tx[DATA_W-2];
                end
            end
            ST_RACK: begin
                if (scl_rise) begin
                    st_d.acked = ~sda_s;
                end
                if (scl_fall) begin
                    if (st_q.acked) begin
                        st_d.tx     = mem_rd;
                        st_d.pull   = ~mem_rd[DATA_W-1];
                        st_d.bitcnt = '0;
                        st_d.state  = ST_RDATA;
                    end else begin
                        st_d.state = ST_IDLE;
                    end
                end
            end
            default: ;
        endcase

        if (start_det) begin
            st_d.state  = ST_DEVID;
            st_d.bitcnt = '0;
            st_d.pull   = 1'b0;
        end else if (stop_det) begin
            st_d.state = ST_IDLE;
            st_d.pull  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, bitcnt: '0, shreg: '0, tx: '0,
                      addr: '0, rw: 1'b0, acked: 1'b0, pull: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic [ADDR_W-1:0] addr_q;
    twi_state_e        state_q;
    assign addr_q   = st_q.addr;
    assign state_q  = st_q.state;
    assign sda_pull = st_q.pull;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_fall,
    input logic              start_det,
    input logic              sda_pull,
    input logic              wp_in,
    input logic              mem_we,
    input logic [ADDR_W-1:0] addr_q,
    input twi_state_e        state_q
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull);

    assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_DEVID));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    assert_protect_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wp_in);

    assert_pull_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> $past(scl_fall));
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .sda_pull  (sda_pull),
    .wp_in     (wp_in),
    .mem_we    (mem_we),
    .addr_q    (addr_q),
    .state_q   (state_q)
);

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/1ps
module twi_mem_slave_test;
    localparam int Q = 50;
    localparam int H = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit a;
    logic [7:0] d;

    always #2.5 clk = ~clk;

    twi_mem_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .wp_in    (wp),
        .sda_pull (sda_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R9: the pull enable may only move while the bus clock is low
    always @(sda_pull) begin
        if (rst_n) chk(scl_m == 1'b0, "R9 pull change with clock high", scl_m, 0);
    end

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #Q; scl_m = 1'b1; #H; scl_m = 1'b0; #Q;
        end
        sda_m = 1'b1; #Q; scl_m = 1'b1; #(H/2);
        ack = (sda_line == 1'b0);
        #(H/2); scl_m = 1'b0; #Q;
    endtask

    task automatic send_bits(input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = 1'b0; #Q; scl_m = 1'b1; #H; scl_m = 1'b0; #Q;
        end
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; scl_m = 1'b1; #(H/2); b[i] = sda_line; #(H/2); scl_m = 1'b0;
        end
        #Q; sda_m = ~give_ack; #Q; scl_m = 1'b1; #H; scl_m = 1'b0; #Q; sda_m = 1'b1;
    endtask

    // start, write device byte for a page, low address byte
    task automatic point_at(input logic [2:0] pg, input logic [7:0] lo, input string req);
        bit k;
        bus_start();
        send_byte({4'hA, pg, 1'b0}, k); chk(k, req, k, 1);
        send_byte(lo, k);               chk(k, req, k, 1);
    endtask

    task automatic t_reset();
        chk(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);
    endtask

    task automatic t_write_read();
        bit k;
        bus_start();
        send_byte(8'hA6, k); chk(k, "R3 device byte acked", k, 1);
        send_byte(8'hF0, k); chk(k, "R4 address byte acked", k, 1);
        send_byte(8'hA5, k); chk(k, "R4 data acked", k, 1);
        send_byte(8'h3C, k); chk(k, "R4 data acked", k, 1);
        send_byte(8'h81, k); chk(k, "R4 data acked", k, 1);
        bus_stop();
        bus_start();
        send_byte(8'hA6, k); chk(k, "R10 acked right after write", k, 1);
        send_byte(8'hF0, k); chk(k, "R4 address byte acked", k, 1);
        bus_start();
        send_byte(8'hA7, k); chk(k, "R2 repeated start read acked", k, 1);
        recv_byte(1'b1, d); chk(d == 8'hA5, "R6 first byte", d, 8'hA5);
        recv_byte(1'b1, d); chk(d == 8'h3C, "R5 next byte", d, 8'h3C);
        recv_byte(1'b0, d); chk(d == 8'h81, "R5 third byte", d, 8'h81);
        #Q; chk(sda_pull == 1'b0, "R6 released after nack", sda_pull, 0);
        bus_stop();
    endtask

    task automatic t_bad_id();
        bit k;
        bus_start();
        send_byte(8'h90, k); chk(!k, "R3 foreign id not acked", k, 0);
        send_byte(8'hA0, k); chk(!k, "R3 ignored until start", k, 0);
        bus_stop();
        send_byte(8'hA0, k); chk(!k, "R2 no ack without start", k, 0);
        bus_stop();
    endtask

    task automatic t_wrap();
        bit k;
        point_at(3'd7, 8'hFF, "R4 wrap setup");
        send_byte(8'h11, k); chk(k, "R4 data acked at top", k, 1);
        send_byte(8'h22, k); chk(k, "R5 data acked after wrap", k, 1);
        bus_stop();
        point_at(3'd7, 8'hFF, "R5 wrap read setup");
        bus_start();
        send_byte(8'hAF, k); chk(k, "R3 read id acked", k, 1);
        recv_byte(1'b1, d); chk(d == 8'h11, "R5 byte at 7FF", d, 8'h11);
        recv_byte(1'b0, d); chk(d == 8'h22, "R5 byte at 000 after wrap", d, 8'h22);
        bus_stop();
    endtask

    task automatic t_protect();
        bit k;
        point_at(3'd0, 8'h10, "R7 setup");
        send_byte(8'h77, k); chk(k, "R4 data acked", k, 1);
        bus_stop();
        wp = 1'b1;
        point_at(3'd0, 8'h10, "R7 address acked under protect");
        send_byte(8'h55, k); chk(!k, "R7 protected data not acked", k, 0);
        bus_stop();
        wp = 1'b0;
        bus_start();
        send_byte(8'hA1, k); chk(k, "R3 read id acked", k, 1);
        recv_byte(1'b0, d); chk(d == 8'h77, "R7 content kept and latch held", d, 8'h77);
        bus_stop();
    endtask

    task automatic t_abort();
        bit k;
        point_at(3'd2, 8'h20, "R8 setup");
        send_byte(8'h99, k); chk(k, "R4 data acked", k, 1);
        send_byte(8'h66, k); chk(k, "R4 data acked", k, 1);
        bus_stop();
        point_at(3'd2, 8'h20, "R8 start abort setup");
        send_bits(5);
        bus_start();
        send_byte(8'hA5, k); chk(k, "R2 start mid byte acked", k, 1);
        recv_byte(1'b0, d); chk(d == 8'h99, "R8 start abort kept byte", d, 8'h99);
        bus_stop();
        point_at(3'd2, 8'h21, "R8 stop abort setup");
        send_bits(3);
        bus_stop();
        bus_start();
        send_byte(8'hA5, k); chk(k, "R3 read id acked", k, 1);
        recv_byte(1'b0, d); chk(d == 8'h66, "R8 stop abort kept byte", d, 8'h66);
        bus_stop();
    endtask

    initial begin
        #2;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #100;
        t_reset();
        t_write_read();
        t_bad_id();
        t_wrap();
        t_protect();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule